// File: doc/BRIEF.md
# Wide-Descriptor Translation Table Walker

This block walks a translation-table hierarchy whose entries are 16 bytes wide. It uses a 4 KB granule and 48-bit input addresses. Because each table page holds only 256 entries, a normal lookup resolves 8 address bits. A full walk therefore spans five lookup levels, from level -1 down to level 3. The walker takes one request at a time. A request is a 64-bit virtual address plus a base register value, which is made of a table address and a 2-bit initial skip count. The walker issues one 128-bit read at a time on a plain request/response memory port.

Each descriptor carries a 2-bit skip field. That field decides whether the entry points at a further table or ends the walk as a block or page. The field can also merge several levels into one wider lookup. The walker accumulates two things from every table entry on the path: a contiguous-disable bit and a table access flag. It returns either a physical address with the leaf's attributes, or a fault code together with the level at which the walk stopped.

Levels appear on the ports as an index equal to level + 1, so level -1 is index 0 and level 3 is index 4. The low address bit of the range resolved at index i is lo(i) = 12 + 8*(4 - i).

Top module: `tw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `res_valid` and `mem_req` are 0.
- R2: If bits 63:48 of `req_va` are not all equal, the result carries fault code 2 (address size). `res_lvl` equals `req_skl`, and no memory read is issued.
- R3: The first read is at index `req_skl`. Its address is `req_tbl` + 16 * VA[47:lo(req_skl)].
- R4: A table entry at index i with skip s moves the walk to index n = i+1+s. The next read address is the entry's bits 55:12 (shifted left by 12) + 16 * VA[lo(i)-1:lo(n)].
- R5: An entry with bit 0 clear ends the walk with fault code 1 (translation) and `res_lvl` equal to the current index, whatever its other fields hold.
- R6: A valid entry whose i+1+s exceeds 5 ends the walk with fault code 1 at the current index.
- R7: A valid entry with i+1+s equal to 5 is a leaf. The result has fault code 0 and `res_lvl` = i. `res_pa` is the entry's bits 55:lo(i) joined with VA[lo(i)-1:0]. `res_attr` is entry bits 5:2, and `res_af` is entry bit 10.
- R8: `res_contig` is the leaf's bit 111, forced to 0 when any table entry on the walk had bit 112 set.
- R9: `res_taf` is the AND of bit 10 over all table entries on the walk, and is 1 when there were none.
- R10: `req_ready` is low from acceptance until the cycle after the one-cycle `res_valid` pulse. Only one read is outstanding at a time. `mem_req` is a one-cycle pulse, and `mem_addr` is 16-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_va | input | 64 | Virtual address |
| req_tbl | input | 56 | Base table address |
| req_skl | input | 2 | Base register skip count |
| mem_req | output | 1 | Descriptor read pulse |
| mem_addr | output | 56 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor read data valid |
| mem_rsp_data | input | 128 | Descriptor read data |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 2 | 0 none, 1 translation, 2 address size |
| res_lvl | output | 3 | Level index (level + 1) of leaf or fault |
| res_pa | output | 56 | Output physical address |
| res_attr | output | 4 | Attribute index |
| res_af | output | 1 | Leaf access flag |
| res_taf | output | 1 | AND of table access flags |
| res_contig | output | 1 | Effective contiguous hint |

## Verification
A single response cycle decides three things at once: whether the entry is valid, whether its skip field makes it a leaf, and whether that skip overruns level 3. The bench sweeps every base skip against every sequence of per-level skip values. At chosen steps it marks entries invalid while their skip fields would otherwise have produced a leaf, a further table or an overrun. The validity fault must win in each of these cases: the result must report the current index and no further read may appear. The same sweep also crosses the contiguous-disable bits gathered along the path with the leaf's own contiguous bit.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLAT  = 2'd1,
    FLT_ASIZE = 2'd2
  } tw_fault_e;

  localparam int DESC_W   = 128;
  localparam int B_VALID  = 0;
  localparam int B_ATTR_L = 2;
  localparam int B_AF     = 10;
  localparam int B_ADDR_L = 12;
  localparam int B_SKL_L  = 109;
  localparam int B_CONTIG = 111;
  localparam int B_NOCONT = 112;
endpackage

// File: rtl/tw_index.sv
module tw_index #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 56,
  parameter int GRAN     = 12,
  parameter int STRIDE   = 8,
  parameter int NLVL     = 5,
  parameter int DESC_SH  = 4,
  localparam int LW      = $clog2(NLVL + 1),
  localparam int SW      = $clog2(VA_W + 1)
) (
  input  logic [VA_W-1:0] va,
  input  logic [SW-1:0]   top,
  input  logic [LW-1:0]   lvl,
  input  logic [PA_W-1:0] base,
  output logic [PA_W-1:0] addr
);
  int              lo_i;
  int              width_i;
  logic [VA_W-1:0] span;
  logic [VA_W-1:0] index;

  always_comb begin
    lo_i    = GRAN + STRIDE * (NLVL - 1 - int'(lvl));
    width_i = int'(top) - lo_i;
    span    = {VA_W{1'b1}} >> (VA_W - width_i);
    index   = (va >> lo_i) & span;
    addr    = base + (PA_W'(index) << DESC_SH);
  end
endmodule

// File: rtl/tw_decode.sv
module tw_decode
  import tw_pkg::*;
#(
  parameter int PA_W = 56,
  parameter int NLVL = 5,
  localparam int LW  = $clog2(NLVL + 1)
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [LW-1:0]     lvl,
  output logic              valid,
  output logic [LW:0]       nxt,
  output logic              is_leaf,
  output logic              overrun,
  output logic [PA_W-1:0]   base,
  output logic              nocont,
  output logic              af,
  output logic              contig,
  output logic [3:0]        attr
);
  logic [1:0] skl;

  always_comb begin
    valid   = desc[B_VALID];
    skl     = desc[B_SKL_L +: 2];
    nxt     = {1'b0, lvl} + (LW+1)'(1) + (LW+1)'(skl);
    is_leaf = (nxt == (LW+1)'(NLVL));
    overrun = (nxt > (LW+1)'(NLVL));
    base    = {desc[PA_W-1:B_ADDR_L], {B_ADDR_L{1'b0}}};
    nocont  = desc[B_NOCONT];
    af      = desc[B_AF];
    contig  = desc[B_CONTIG];
    attr    = desc[B_ATTR_L +: 4];
  end
endmodule

// File: rtl/tw_walker.sv
module tw_walker
  import tw_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 56,
  parameter int GRAN   = 12,
  parameter int STRIDE = 8,
  parameter int NLVL   = 5,
  parameter int DESC_BYTES = 16,
  localparam int LW    = $clog2(NLVL + 1),
  localparam int SW    = $clog2(VA_W + 1),
  localparam int DSH   = $clog2(DESC_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_va,
  input  logic [PA_W-1:0]   req_tbl,
  input  logic [1:0]        req_skl,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output logic [1:0]        res_fault,
  output logic [LW-1:0]     res_lvl,
  output logic [PA_W-1:0]   res_pa,
  output logic [3:0]        res_attr,
  output logic              res_af,
  output logic              res_taf,
  output logic              res_contig
);
  function automatic logic [SW-1:0] lo_of(input logic [LW-1:0] l);
    return SW'(GRAN + STRIDE * (NLVL - 1 - int'(l)));
  endfunction

  logic            busy;
  logic [VA_W-1:0] va_r;
  logic [LW-1:0]   lvl_r;
  logic            nocont_r;
  logic            taf_r;

  logic              d_valid, d_leaf, d_over, d_nocont, d_af, d_contig;
  logic [LW:0]       d_nxt;
  logic [PA_W-1:0]   d_base;
  logic [3:0]        d_attr;

  tw_decode #(.PA_W(PA_W), .NLVL(NLVL)) u_dec (
    .desc(mem_rsp_data), .lvl(lvl_r), .valid(d_valid), .nxt(d_nxt),
    .is_leaf(d_leaf), .overrun(d_over), .base(d_base), .nocont(d_nocont),
    .af(d_af), .contig(d_contig), .attr(d_attr)
  );

  logic [VA_W-1:0] ix_va;
  logic [SW-1:0]   ix_top;
  logic [LW-1:0]   ix_lvl;
  logic [PA_W-1:0] ix_base;
  logic [PA_W-1:0] ix_addr;

  always_comb begin
    if (!busy) begin
      ix_va   = req_va[VA_W-1:0];
      ix_top  = SW'(VA_W);
      ix_lvl  = LW'(req_skl);
      ix_base = req_tbl;
    end else begin
      ix_va   = va_r;
      ix_top  = lo_of(lvl_r);
      ix_lvl  = d_nxt[LW-1:0];
      ix_base = d_base;
    end
  end

  tw_index #(.VA_W(VA_W), .PA_W(PA_W), .GRAN(GRAN), .STRIDE(STRIDE),
             .NLVL(NLVL), .DESC_SH(DSH)) u_ix (
    .va(ix_va), .top(ix_top), .lvl(ix_lvl), .base(ix_base), .addr(ix_addr)
  );

  logic            va_canon;
  logic [PA_W-1:0] keep_mask;

  always_comb begin
    va_canon  = (&req_va[63:VA_W]) | ~(|req_va[63:VA_W]);
    keep_mask = {PA_W{1'b1}} << lo_of(lvl_r);
  end

  assign req_ready = !busy && !res_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      va_r       <= '0;
      lvl_r      <= '0;
      nocont_r   <= 1'b0;
      taf_r      <= 1'b1;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      res_valid  <= 1'b0;
      res_fault  <= FLT_NONE;
      res_lvl    <= '0;
      res_pa     <= '0;
      res_attr   <= '0;
      res_af     <= 1'b0;
      res_taf    <= 1'b0;
      res_contig <= 1'b0;
    end else begin
      mem_req   <= 1'b0;
      res_valid <= 1'b0;
      if (req_ready && req_valid) begin
        if (!va_canon) begin
          res_valid <= 1'b1;
          res_fault <= FLT_ASIZE;
          res_lvl   <= LW'(req_skl);
        end else begin
          busy     <= 1'b1;
          va_r     <= req_va[VA_W-1:0];
          lvl_r    <= LW'(req_skl);
          nocont_r <= 1'b0;
          taf_r    <= 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= ix_addr;
        end
      end else if (busy && mem_rsp_valid) begin
        if (!d_valid || d_over) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_fault <= FLT_XLAT;
          res_lvl   <= lvl_r;
        end else if (d_leaf) begin
          busy       <= 1'b0;
          res_valid  <= 1'b1;
          res_fault  <= FLT_NONE;
          res_lvl    <= lvl_r;
          res_pa     <= (d_base & keep_mask) | (PA_W'(va_r) & ~keep_mask);
          res_attr   <= d_attr;
          res_af     <= d_af;
          res_taf    <= taf_r;
          res_contig <= d_contig & ~nocont_r;
        end else begin
          lvl_r    <= d_nxt[LW-1:0];
          nocont_r <= nocont_r | d_nocont;
          taf_r    <= taf_r & d_af;
          mem_req  <= 1'b1;
          mem_addr <= ix_addr;
        end
      end
    end
  end
endmodule

// File: rtl/tw_walker_chk.sv
module tw_walker_chk #(
  parameter int PA_W = 56,
  parameter int LW   = 3,
  parameter int DSH  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_rsp_valid,
  input logic            res_valid,
  input logic [1:0]      res_fault,
  input logic [LW-1:0]   res_lvl
);
  // R10
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R10
  a_r10_addr_align: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[DSH-1:0] == '0));
  // R10
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R10
  a_r10_ready_after_result: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> req_ready);
  // R10
  a_r10_no_read_when_idle: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
  // R2
  a_r2_fault_code_legal: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_fault != 2'd3));
  // R7
  a_r7_leaf_level_range: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault == 2'd0) |-> (res_lvl != '0 && res_lvl <= LW'(4)));
endmodule

bind tw_walker tw_walker_chk #(.PA_W(PA_W), .LW(LW), .DSH(DSH)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
  .res_valid(res_valid), .res_fault(res_fault), .res_lvl(res_lvl)
);

// File: tb/tb_tw_walker.sv
`timescale 1ns/1ps
module tb_tw_walker;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [63:0]  req_va = '0;
  logic [55:0]  req_tbl = '0;
  logic [1:0]   req_skl = '0;
  logic         mem_req;
  logic [55:0]  mem_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic         res_valid;
  logic [1:0]   res_fault;
  logic [2:0]   res_lvl;
  logic [55:0]  res_pa;
  logic [3:0]   res_attr;
  logic         res_af, res_taf, res_contig;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tw_walker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_tbl(req_tbl), .req_skl(req_skl),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
    .res_lvl(res_lvl), .res_pa(res_pa), .res_attr(res_attr), .res_af(res_af),
    .res_taf(res_taf), .res_contig(res_contig)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired act %0d exp below 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  function automatic int lo_of(input int i);
    return 12 + 8 * (4 - i);
  endfunction

  localparam logic [63:0] M56 = 64'h00FF_FFFF_FFFF_FFFF;

  task automatic wait_mem(output bit seen);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      if (mem_req) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic walk(input logic [63:0] va, input logic [63:0] tbl,
                      input int bskip, input int pat, input int flags,
                      input int bad_step);
    int cur, top, step, s, nl;
    logic [63:0] base, nb, idx, exp_addr, exp_pa, lmask;
    logic [127:0] d;
    bit dis, taf, done, seen, ok_valid;
    int exp_fault, exp_lvl;
    bit exp_c, exp_af;
    logic [3:0] exp_attr;
    cur = bskip; top = 48; base = tbl; dis = 0; taf = 1; step = 0; done = 0;
    exp_fault = 0; exp_lvl = 0; exp_c = 0; exp_af = 0; exp_attr = 0; exp_pa = 0;
    @(negedge clk);
    req_va = va; req_tbl = tbl[55:0]; req_skl = 2'(bskip); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 ready low after accept", {63'd0, req_ready}, 64'd0);
    while (!done) begin
      wait_mem(seen);
      idx = (va[47:0] >> lo_of(cur)) & ((64'd1 << (top - lo_of(cur))) - 64'd1);
      exp_addr = (base + (idx << 4)) & M56;
      chk(seen && ({8'd0, mem_addr} == exp_addr),
          (step == 0) ? "R3 first read address" : "R4 next read address",
          {8'd0, mem_addr}, exp_addr);
      if (!seen) return;
      s  = (pat >> (2 * step)) & 3;
      nl = cur + 1 + s;
      ok_valid = (step != bad_step);
      nb = (((64'(step) + 64'd1) * 64'h0000_0123_4567_8000) ^ (64'(pat) << 16)
            ^ 64'h00A5_0000_0000_0000) & M56 & ~64'hFFF;
      d = '0;
      d[0] = ok_valid;
      d[110:109] = 2'(s);
      d[55:12] = nb[55:12];
      d[112] = (flags >> step) & 1;
      d[10]  = (flags >> (step + 5)) & 1;
      d[111] = (flags >> 10) & 1;
      d[5:2] = 4'((flags >> 12) & 15);
      @(negedge clk);
      chk(!mem_req, "R10 single outstanding read", {63'd0, mem_req}, 64'd0);
      mem_rsp_data = d; mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (!ok_valid) begin
        exp_fault = 1; exp_lvl = cur; done = 1;
      end else if (nl > 5) begin
        exp_fault = 1; exp_lvl = cur; done = 1;
      end else if (nl == 5) begin
        exp_fault = 0; exp_lvl = cur; done = 1;
        lmask = (64'd1 << lo_of(cur)) - 64'd1;
        exp_pa = ((nb & ~lmask) | ({16'd0, va[47:0]} & lmask)) & M56;
        exp_c = d[111] & ~dis; exp_af = d[10]; exp_attr = d[5:2];
      end else begin
        dis = dis | d[112]; taf = taf & d[10];
        top = lo_of(cur); cur = nl; base = nb; step++;
      end
    end
    chk(res_valid, "R10 result pulse", {63'd0, res_valid}, 64'd1);
    if (!ok_valid)
      chk(res_fault == 2'(exp_fault) && res_lvl == 3'(exp_lvl),
          "R5 invalid entry fault", {res_fault, 1'b0, res_lvl},
          {2'(exp_fault), 1'b0, 3'(exp_lvl)});
    else if (exp_fault == 1)
      chk(res_fault == 2'(exp_fault) && res_lvl == 3'(exp_lvl),
          "R6 skip overrun fault", {res_fault, 1'b0, res_lvl},
          {2'(exp_fault), 1'b0, 3'(exp_lvl)});
    else begin
      chk(res_fault == 2'd0 && res_lvl == 3'(exp_lvl) && {8'd0, res_pa} == exp_pa
          && res_attr == exp_attr && res_af == exp_af,
          "R7 leaf result", {8'd0, res_pa}, exp_pa);
      chk(res_contig == exp_c, "R8 contiguous", {63'd0, res_contig}, {63'd0, exp_c});
      chk(res_taf == taf, "R9 table access flag", {63'd0, res_taf}, {63'd0, taf});
    end
    @(negedge clk);
    chk(!res_valid && req_ready, "R10 idle after result",
        {62'd0, res_valid, req_ready}, 64'd1);
  endtask

  task automatic asize(input logic [63:0] va, input int bskip);
    bit any;
    any = 0;
    @(negedge clk);
    req_va = va; req_tbl = 56'h1000; req_skl = 2'(bskip); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    any = mem_req;
    chk(res_valid && res_fault == 2'd2 && res_lvl == 3'(bskip),
        "R2 address size fault", {res_valid, res_fault, res_lvl},
        {1'b1, 2'd2, 3'(bskip)});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      any = any | mem_req;
    end
    chk(!any, "R2 no read issued", {63'd0, any}, 64'd0);
  endtask

  initial begin
    logic [63:0] va48, va, tbl;
    int bad;
    repeat (3) @(negedge clk);
    chk(req_ready && !res_valid && !mem_req, "R1 reset state",
        {61'd0, req_ready, res_valid, mem_req}, 64'd4);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !res_valid && !mem_req, "R1 after reset release",
        {61'd0, req_ready, res_valid, mem_req}, 64'd4);
    for (int b = 0; b < 4; b++) begin
      for (int p = 0; p < 256; p++) begin
        va48 = (64'(p) * 64'h9E37_79B9_7F4A + 64'(b) * 64'h1234_5678_9ABC
                + 64'h0000_8765_4321_0FED) & 64'h0000_FFFF_FFFF_FFFF;
        va = va48[47] ? (va48 | 64'hFFFF_0000_0000_0000) : va48;
        tbl = ((64'(p) * 64'h51 + 64'(b) + 64'd1) << 12 | 64'h0033_0000_0000_0000) & M56;
        bad = (p % 7 == 3) ? ((p >> 3) & 3) : 99;
        walk(va, tbl, b, p, (p * 2654435 + b * 977) & 32'hFFFF, bad);
      end
    end
    asize(64'h0001_0000_0000_0000, 0);
    asize(64'hFFFE_8000_0000_0000, 2);
    asize(64'h8000_0000_0000_1000, 3);
    asize(64'h7FFF_FFFF_FFFF_FFFF, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule